// File: doc/BRIEF.md
# Control Register Mode Unit

This block keeps the processor's three main control registers (the mode register, the page-table base and the extension register), the long-mode enable and active bits, and the gate for address line 20. It turns writes to them into the hidden mode flags that the decode, segmentation and floating-point logic read every cycle. It also turns them into the side-effect pulses that the memory system and the pipeline need: a translation-cache flush, a pipeline exit, and a clear of the upper instruction-pointer half.

Each register has its own write strobe and all of them share one data bus. A write updates the register on the clock edge where its strobe is sampled. Any pulse it causes is high for exactly the next cycle. Several strobes may be active in the same cycle. Every decision is made on the values held before that edge. The mode-register write is gated on the extension register and the enable bit. The flush and exit pulses fire only when specific bits actually change.

Top module: `mode_ctl_regs`

## Requirements
- R1: After reset the mode register reads 0x60000010, the base and extension registers read 0, the address mask reads 0xFFFFFFFF, ADDSEG is 1, all other flags, long-mode bits and pulses are 0.
- R2: An accepted mode-register write stores the bus value with bit 4 forced to 1.
- R3: A mode-register write whose value differs from the stored one in bit 31 (paging), bit 16 (write protect) or bit 0 (protection enable) raises tlbFlush for the one following cycle, even when the write is refused.
- R4: A write taking bit 31 from 0 to 1 while the enable bit is 1 and extension bit 5 (PAE) is 1 sets the long-mode active bit.
- R5: A write taking bit 31 from 0 to 1 while the enable bit is 1 and extension bit 5 is 0 is refused: the mode register, the flags and the active bit keep their values.
- R6: A write taking bit 31 from 1 to 0 while long mode is active clears the active bit and CS64, and raises ipHiClear for the one following cycle.
- R7: peFlag equals mode bit 0; ADDSEG is forced to 1 by an accepted write with bit 0 clear, and an ADDSEG load takes effect only while peFlag is 1.
- R8: mpFlag, emFlag and tsFlag equal mode-register bits 1, 2 and 3.
- R9: An extension write whose value differs from the stored one in bit 7, 5 or 4 raises tlbFlush for the one following cycle; other bit changes raise no flush.
- R10: With HAS_SSE = 0, bit 9 of an extension write is stored as 0; osfxsrFlag always equals stored extension bit 9.
- R11: A base-register write stores the bus value and raises tlbFlush the next cycle only when mode bit 31 is 1.
- R12: An A20 request with a state different from mask bit 20 sets the mask to 0xFFEFFFFF with bit 20 equal to the request, and raises both pipeExit and tlbFlush for one cycle; a request with the same state changes nothing.
- R13: A CS64 load takes effect only while long mode is active; otherwise CS64 becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cr0WrEn | input | 1 | Mode register write strobe |
| cr3WrEn | input | 1 | Page-table base write strobe |
| cr4WrEn | input | 1 | Extension register write strobe |
| wrData | input | XLEN | Shared write data |
| lmeWrEn | input | 1 | Long-mode enable write strobe |
| lmeIn | input | 1 | Long-mode enable value |
| cs64WrEn | input | 1 | CS64 load strobe from segment loader |
| cs64In | input | 1 | CS64 value |
| addsegWrEn | input | 1 | ADDSEG load strobe from segment loader |
| addsegIn | input | 1 | ADDSEG value |
| a20SetEn | input | 1 | A20 gate request |
| a20In | input | 1 | Requested A20 state |
| cr0Q | output | XLEN | Mode register |
| cr3Q | output | XLEN | Page-table base |
| cr4Q | output | XLEN | Extension register |
| lmeQ | output | 1 | Long-mode enable |
| lmaQ | output | 1 | Long-mode active |
| peFlag | output | 1 | Protection enabled |
| addsegFlag | output | 1 | Segment base add needed |
| mpFlag | output | 1 | Monitor coprocessor |
| emFlag | output | 1 | FPU emulation |
| tsFlag | output | 1 | Task switched |
| osfxsrFlag | output | 1 | OS supports extended FP save |
| cs64Flag | output | 1 | 64-bit code segment |
| tlbFlush | output | 1 | Translation flush pulse |
| pipeExit | output | 1 | Pipeline exit pulse |
| ipHiClear | output | 1 | Clear upper instruction pointer pulse |
| a20Mask | output | XLEN | Physical address mask |

## Verification
On every cycle the assertions check the invariants: bit 4 stays set, ADDSEG stays high outside protected mode, long mode active implies paging and CS64 implies long mode. They also check that the A20 mask differs from all ones only in bit 20, that the flush follows a paging or A20 change, and that exit pulses come only from A20 changes. Refused long-mode entry, the exact flag values after mixed simultaneous writes, the silence of a repeated A20 request and the masking of bit 9 in a build without SSE can be shown only by the bench's scenarios, which compare every output with a reference model after each cycle.

// File: rtl/mode_ctl_pkg.sv
package mode_ctl_pkg;
  localparam int PgBit     = 31;
  localparam int WpBit     = 16;
  localparam int EtBit     = 4;
  localparam int PeBit     = 0;
  localparam int MpBit     = 1;
  localparam int EmBit     = 2;
  localparam int TsBit     = 3;
  localparam int PgeBit    = 7;
  localparam int PaeBit    = 5;
  localparam int PseBit    = 4;
  localparam int OsfxsrBit = 9;
  localparam int A20Bit    = 20;

  typedef struct packed {
    logic cr0Load;
    logic lmaSet;
    logic lmaClr;
    logic cr3Load;
    logic cr4Load;
    logic lmeLoad;
    logic cs64Load;
    logic addsegLoad;
    logic a20Load;
    logic flushReq;
    logic exitReq;
  } ctlStrobe_t;
endpackage

// File: rtl/mode_ctl_ctrl.sv
module mode_ctl_ctrl
  import mode_ctl_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit HAS_SSE = 1'b1
) (
  input  logic            cr0WrEn,
  input  logic            cr3WrEn,
  input  logic            cr4WrEn,
  input  logic [XLEN-1:0] wrData,
  input  logic            lmeWrEn,
  input  logic            cs64WrEn,
  input  logic            addsegWrEn,
  input  logic            a20SetEn,
  input  logic            a20In,
  input  logic [XLEN-1:0] cr0Q,
  input  logic [XLEN-1:0] cr4Q,
  input  logic            lmeQ,
  input  logic            lmaQ,
  input  logic            peQ,
  input  logic            a20Q,
  output ctlStrobe_t      strobes,
  output logic [XLEN-1:0] cr4Masked
);
  localparam logic [XLEN-1:0] Cr0FlushMask =
    (XLEN'(1) << PgBit) | (XLEN'(1) << WpBit) | (XLEN'(1) << PeBit);
  localparam logic [XLEN-1:0] Cr4FlushMask =
    (XLEN'(1) << PgeBit) | (XLEN'(1) << PaeBit) | (XLEN'(1) << PseBit);
  localparam logic [XLEN-1:0] OsfxsrMask = XLEN'(1) << OsfxsrBit;

  logic pgRise, pgFall, enterLong, refuse, cr0Flush, cr4Flush, cr3Flush, a20Change;

  generate
    if (HAS_SSE) begin : g_sse
      assign cr4Masked = wrData;
    end else begin : g_nosse
      assign cr4Masked = wrData & ~OsfxsrMask;
    end
  endgenerate

  always_comb begin
    pgRise    = cr0WrEn && !cr0Q[PgBit] && wrData[PgBit];
    pgFall    = cr0WrEn && cr0Q[PgBit] && !wrData[PgBit];
    enterLong = pgRise && lmeQ;
    refuse    = enterLong && !cr4Q[PaeBit];
    cr0Flush  = cr0WrEn && (((wrData ^ cr0Q) & Cr0FlushMask) != '0);
    cr4Flush  = cr4WrEn && (((cr4Masked ^ cr4Q) & Cr4FlushMask) != '0);
    cr3Flush  = cr3WrEn && cr0Q[PgBit];
    a20Change = a20SetEn && (a20In != a20Q);

    strobes            = '0;
    strobes.cr0Load    = cr0WrEn && !refuse;
    strobes.lmaSet     = enterLong && !refuse;
    strobes.lmaClr     = pgFall && lmaQ;
    strobes.cr3Load    = cr3WrEn;
    strobes.cr4Load    = cr4WrEn;
    strobes.lmeLoad    = lmeWrEn;
    strobes.cs64Load   = cs64WrEn;
    strobes.addsegLoad = addsegWrEn && peQ;
    strobes.a20Load    = a20Change;
    strobes.flushReq   = cr0Flush || cr4Flush || cr3Flush || a20Change;
    strobes.exitReq    = a20Change;
  end
endmodule

// File: rtl/mode_ctl_dp.sv
module mode_ctl_dp
  import mode_ctl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      strobes,
  input  logic [XLEN-1:0] wrData,
  input  logic [XLEN-1:0] cr4Masked,
  input  logic            lmeIn,
  input  logic            cs64In,
  input  logic            addsegIn,
  input  logic            a20In,
  output logic [XLEN-1:0] cr0Q,
  output logic [XLEN-1:0] cr3Q,
  output logic [XLEN-1:0] cr4Q,
  output logic            lmeQ,
  output logic            lmaQ,
  output logic            peQ,
  output logic            addsegQ,
  output logic            mpQ,
  output logic            emQ,
  output logic            tsQ,
  output logic            osfxsrQ,
  output logic            cs64Q,
  output logic            flushQ,
  output logic            exitQ,
  output logic            ipClrQ,
  output logic [XLEN-1:0] a20MaskQ
);
  localparam logic [XLEN-1:0] Cr0Reset = XLEN'(32'h6000_0010);
  localparam logic [XLEN-1:0] A20Bit1  = XLEN'(1) << A20Bit;
  localparam logic [XLEN-1:0] EtMask   = XLEN'(1) << EtBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cr0Q    <= Cr0Reset;
      peQ     <= 1'b0;
      mpQ     <= 1'b0;
      emQ     <= 1'b0;
      tsQ     <= 1'b0;
      addsegQ <= 1'b1;
    end else begin
      if (strobes.cr0Load) begin
        cr0Q <= wrData | EtMask;
        peQ  <= wrData[PeBit];
        mpQ  <= wrData[MpBit];
        emQ  <= wrData[EmBit];
        tsQ  <= wrData[TsBit];
      end
      if (strobes.cr0Load && !wrData[PeBit]) addsegQ <= 1'b1;
      else if (strobes.addsegLoad)           addsegQ <= addsegIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cr3Q    <= '0;
      cr4Q    <= '0;
      osfxsrQ <= 1'b0;
      lmeQ    <= 1'b0;
    end else begin
      if (strobes.cr3Load) cr3Q <= wrData;
      if (strobes.cr4Load) begin
        cr4Q    <= cr4Masked;
        osfxsrQ <= cr4Masked[OsfxsrBit];
      end
      if (strobes.lmeLoad) lmeQ <= lmeIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lmaQ  <= 1'b0;
      cs64Q <= 1'b0;
    end else begin
      if (strobes.lmaClr)      lmaQ <= 1'b0;
      else if (strobes.lmaSet) lmaQ <= 1'b1;
      if (strobes.lmaClr)        cs64Q <= 1'b0;
      else if (strobes.cs64Load) cs64Q <= cs64In && lmaQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      a20MaskQ <= '1;
      flushQ   <= 1'b0;
      exitQ    <= 1'b0;
      ipClrQ   <= 1'b0;
    end else begin
      if (strobes.a20Load) a20MaskQ <= ~A20Bit1 | (a20In ? A20Bit1 : '0);
      flushQ <= strobes.flushReq;
      exitQ  <= strobes.exitReq;
      ipClrQ <= strobes.lmaClr;
    end
  end
endmodule

// File: rtl/mode_ctl_regs.sv
module mode_ctl_regs
  import mode_ctl_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit HAS_SSE = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cr0WrEn,
  input  logic            cr3WrEn,
  input  logic            cr4WrEn,
  input  logic [XLEN-1:0] wrData,
  input  logic            lmeWrEn,
  input  logic            lmeIn,
  input  logic            cs64WrEn,
  input  logic            cs64In,
  input  logic            addsegWrEn,
  input  logic            addsegIn,
  input  logic            a20SetEn,
  input  logic            a20In,
  output logic [XLEN-1:0] cr0Q,
  output logic [XLEN-1:0] cr3Q,
  output logic [XLEN-1:0] cr4Q,
  output logic            lmeQ,
  output logic            lmaQ,
  output logic            peFlag,
  output logic            addsegFlag,
  output logic            mpFlag,
  output logic            emFlag,
  output logic            tsFlag,
  output logic            osfxsrFlag,
  output logic            cs64Flag,
  output logic            tlbFlush,
  output logic            pipeExit,
  output logic            ipHiClear,
  output logic [XLEN-1:0] a20Mask
);
  ctlStrobe_t      strobes;
  logic [XLEN-1:0] cr4Masked;

  mode_ctl_ctrl #(.XLEN(XLEN), .HAS_SSE(HAS_SSE)) u_ctrl (
    .cr0WrEn(cr0WrEn), .cr3WrEn(cr3WrEn), .cr4WrEn(cr4WrEn), .wrData(wrData),
    .lmeWrEn(lmeWrEn), .cs64WrEn(cs64WrEn), .addsegWrEn(addsegWrEn),
    .a20SetEn(a20SetEn), .a20In(a20In),
    .cr0Q(cr0Q), .cr4Q(cr4Q), .lmeQ(lmeQ), .lmaQ(lmaQ), .peQ(peFlag),
    .a20Q(a20Mask[A20Bit]),
    .strobes(strobes), .cr4Masked(cr4Masked)
  );

  mode_ctl_dp #(.XLEN(XLEN)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData), .cr4Masked(cr4Masked),
    .lmeIn(lmeIn), .cs64In(cs64In), .addsegIn(addsegIn), .a20In(a20In),
    .cr0Q(cr0Q), .cr3Q(cr3Q), .cr4Q(cr4Q), .lmeQ(lmeQ), .lmaQ(lmaQ),
    .peQ(peFlag), .addsegQ(addsegFlag), .mpQ(mpFlag), .emQ(emFlag), .tsQ(tsFlag),
    .osfxsrQ(osfxsrFlag), .cs64Q(cs64Flag), .flushQ(tlbFlush), .exitQ(pipeExit),
    .ipClrQ(ipHiClear), .a20MaskQ(a20Mask)
  );
endmodule

// File: rtl/mode_ctl_regs_chk.sv
module mode_ctl_regs_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            cr0WrEn,
  input logic            cr3WrEn,
  input logic [XLEN-1:0] wrData,
  input logic            a20SetEn,
  input logic            a20In,
  input logic [XLEN-1:0] cr0Q,
  input logic            lmaQ,
  input logic            peFlag,
  input logic            addsegFlag,
  input logic            cs64Flag,
  input logic            tlbFlush,
  input logic            pipeExit,
  input logic [XLEN-1:0] a20Mask
);
  localparam logic [XLEN-1:0] A20One = XLEN'(1) << 20;

  a_r2_et_held: assert property (@(posedge clk) disable iff (!rstN) cr0Q[4]);

  a_r7_addseg_real: assert property (@(posedge clk) disable iff (!rstN)
    !peFlag |-> addsegFlag);

  a_r4_lma_needs_pg: assert property (@(posedge clk) disable iff (!rstN)
    lmaQ |-> cr0Q[31]);

  a_r13_cs64_long: assert property (@(posedge clk) disable iff (!rstN)
    cs64Flag |-> lmaQ);

  a_r3_pg_flush: assert property (@(posedge clk) disable iff (!rstN)
    cr0WrEn && (wrData[31] != cr0Q[31]) |=> tlbFlush);

  a_r11_base_flush: assert property (@(posedge clk) disable iff (!rstN)
    cr3WrEn && cr0Q[31] |=> tlbFlush);

  a_r12_a20_change: assert property (@(posedge clk) disable iff (!rstN)
    a20SetEn && (a20In != a20Mask[20]) |=> pipeExit && tlbFlush && (a20Mask[20] == $past(a20In)));

  a_r12_exit_source: assert property (@(posedge clk) disable iff (!rstN)
    !(a20SetEn && (a20In != a20Mask[20])) |=> !pipeExit);

  a_r12_mask_shape: assert property (@(posedge clk) disable iff (!rstN)
    (a20Mask | A20One) == '1);
endmodule

bind mode_ctl_regs mode_ctl_regs_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rstN(rstN), .cr0WrEn(cr0WrEn), .cr3WrEn(cr3WrEn), .wrData(wrData),
  .a20SetEn(a20SetEn), .a20In(a20In), .cr0Q(cr0Q), .lmaQ(lmaQ), .peFlag(peFlag),
  .addsegFlag(addsegFlag), .cs64Flag(cs64Flag), .tlbFlush(tlbFlush),
  .pipeExit(pipeExit), .a20Mask(a20Mask)
);

// File: tb/test_mode_ctl_regs.sv
module test_mode_ctl_regs;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cr0WrEn = 0, cr3WrEn = 0, cr4WrEn = 0, lmeWrEn = 0, lmeIn = 0;
  logic cs64WrEn = 0, cs64In = 0, addsegWrEn = 0, addsegIn = 0, a20SetEn = 0, a20In = 0;
  logic [31:0] wrData = '0;

  logic [31:0] cr0Q, cr3Q, cr4Q, a20Mask, cr4QN, cr0QN, cr3QN, a20MaskN;
  logic lmeQ, lmaQ, peFlag, addsegFlag, mpFlag, emFlag, tsFlag, osfxsrFlag, cs64Flag;
  logic tlbFlush, pipeExit, ipHiClear;
  logic lmeN, lmaN, peN, addN, mpN, emN, tsN, osfN, cs64N, flN, exN, ipN;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  mode_ctl_regs i_mode_ctl_regs (
    .clk(clk), .rstN(rstN), .cr0WrEn(cr0WrEn), .cr3WrEn(cr3WrEn), .cr4WrEn(cr4WrEn),
    .wrData(wrData), .lmeWrEn(lmeWrEn), .lmeIn(lmeIn), .cs64WrEn(cs64WrEn), .cs64In(cs64In),
    .addsegWrEn(addsegWrEn), .addsegIn(addsegIn), .a20SetEn(a20SetEn), .a20In(a20In),
    .cr0Q(cr0Q), .cr3Q(cr3Q), .cr4Q(cr4Q), .lmeQ(lmeQ), .lmaQ(lmaQ), .peFlag(peFlag),
    .addsegFlag(addsegFlag), .mpFlag(mpFlag), .emFlag(emFlag), .tsFlag(tsFlag),
    .osfxsrFlag(osfxsrFlag), .cs64Flag(cs64Flag), .tlbFlush(tlbFlush), .pipeExit(pipeExit),
    .ipHiClear(ipHiClear), .a20Mask(a20Mask)
  );

  mode_ctl_regs #(.HAS_SSE(1'b0)) i_mode_ctl_regs_nosse (
    .clk(clk), .rstN(rstN), .cr0WrEn(cr0WrEn), .cr3WrEn(cr3WrEn), .cr4WrEn(cr4WrEn),
    .wrData(wrData), .lmeWrEn(lmeWrEn), .lmeIn(lmeIn), .cs64WrEn(cs64WrEn), .cs64In(cs64In),
    .addsegWrEn(addsegWrEn), .addsegIn(addsegIn), .a20SetEn(a20SetEn), .a20In(a20In),
    .cr0Q(cr0QN), .cr3Q(cr3QN), .cr4Q(cr4QN), .lmeQ(lmeN), .lmaQ(lmaN), .peFlag(peN),
    .addsegFlag(addN), .mpFlag(mpN), .emFlag(emN), .tsFlag(tsN),
    .osfxsrFlag(osfN), .cs64Flag(cs64N), .tlbFlush(flN), .pipeExit(exN),
    .ipHiClear(ipN), .a20Mask(a20MaskN)
  );

  // reference state
  logic [31:0] mCr0, mCr3, mCr4, mCr4N, mMask;
  logic mLme, mLma, mCs64, mAdd, mPe, mMp, mEm, mTs, mOsf, mOsfN, mFl, mEx, mIp;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mCr0 = 32'h6000_0010; mCr3 = 0; mCr4 = 0; mCr4N = 0; mMask = 32'hFFFF_FFFF;
    mLme = 0; mLma = 0; mCs64 = 0; mAdd = 1; mPe = 0; mMp = 0; mEm = 0; mTs = 0;
    mOsf = 0; mOsfN = 0; mFl = 0; mEx = 0; mIp = 0;
  endtask

  // next state from the requirements, using values held before the edge
  task automatic modelStep();
    logic [31:0] o0, o4, d4n;
    logic oLma, oLme, oPe, rise, fall, refuse, fl, ex, ip;
    o0 = mCr0; o4 = mCr4; oLma = mLma; oLme = mLme; oPe = mPe;
    fl = 0; ex = 0; ip = 0;
    if (cs64WrEn) mCs64 = cs64In & oLma;                                // R13
    if (addsegWrEn && oPe) mAdd = addsegIn;                             // R7
    if (cr0WrEn) begin
      rise = !o0[31] && wrData[31];
      fall = o0[31] && !wrData[31];
      refuse = rise && oLme && !o4[5];                                  // R5
      if (((wrData ^ o0) & 32'h8001_0001) != 0) fl = 1;                 // R3
      if (!refuse) begin
        mCr0 = wrData | 32'h10;                                         // R2
        mPe = wrData[0]; mMp = wrData[1]; mEm = wrData[2]; mTs = wrData[3];
        if (!wrData[0]) mAdd = 1;
        if (rise && oLme) mLma = 1;                                     // R4
        if (fall && oLma) begin mLma = 0; mCs64 = 0; ip = 1; end        // R6
      end
    end
    if (cr3WrEn) begin mCr3 = wrData; if (o0[31]) fl = 1; end           // R11
    if (cr4WrEn) begin
      if (((wrData ^ o4) & 32'h0000_00B0) != 0) fl = 1;                 // R9
      mCr4 = wrData; mOsf = wrData[9];
      d4n = wrData & ~32'h200; mCr4N = d4n; mOsfN = d4n[9];             // R10
    end
    if (lmeWrEn) mLme = lmeIn;
    if (a20SetEn && (a20In != mMask[20])) begin                         // R12
      mMask = 32'hFFEF_FFFF | (32'(a20In) << 20); fl = 1; ex = 1;
    end
    mFl = fl; mEx = ex; mIp = ip;
  endtask

  task automatic compareAll();
    chk("R2 cr0", cr0Q, mCr0);
    chk("R11 cr3", cr3Q, mCr3);
    chk("R9 cr4", cr4Q, mCr4);
    chk("R4 lma", 32'(lmaQ), 32'(mLma));
    chk("R7 pe", 32'(peFlag), 32'(mPe));
    chk("R7 addseg", 32'(addsegFlag), 32'(mAdd));
    chk("R8 mp/em/ts", {29'd0, tsFlag, emFlag, mpFlag}, {29'd0, mTs, mEm, mMp});
    chk("R10 osfxsr", 32'(osfxsrFlag), 32'(mOsf));
    chk("R13 cs64", 32'(cs64Flag), 32'(mCs64));
    chk("R3 tlbFlush", 32'(tlbFlush), 32'(mFl));
    chk("R12 pipeExit", 32'(pipeExit), 32'(mEx));
    chk("R12 a20Mask", a20Mask, mMask);
    chk("R6 ipHiClear", 32'(ipHiClear), 32'(mIp));
    chk("R10 nosse cr4", cr4QN, mCr4N);
    chk("R10 nosse osfxsr", 32'(osfN), 32'(mOsfN));
  endtask

  task automatic idle();
    cr0WrEn = 0; cr3WrEn = 0; cr4WrEn = 0; lmeWrEn = 0; cs64WrEn = 0;
    addsegWrEn = 0; a20SetEn = 0;
  endtask

  task automatic step();
    modelStep();
    @(posedge clk);
    #2;
    compareAll();
    idle();
  endtask

  initial begin
    #(8 * 150000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(posedge clk);
    #2; rstN = 1'b1;
    // R1 reset state
    chk("R1 cr0 reset", cr0Q, 32'h6000_0010);
    chk("R1 mask reset", a20Mask, 32'hFFFF_FFFF);
    chk("R1 addseg reset", 32'(addsegFlag), 32'd1);
    chk("R1 lma/pulses reset", {28'd0, lmaQ, tlbFlush, pipeExit, ipHiClear}, 32'd0);
    compareAll();

    // R5 refused entry: enable set, PAE clear
    lmeWrEn = 1; lmeIn = 1; step();
    cr0WrEn = 1; wrData = 32'h8000_0001; step();
    chk("R5 cr0 kept", cr0Q, 32'h6000_0010);
    chk("R5 lma stays 0", 32'(lmaQ), 32'd0);
    chk("R3 flush on refused", 32'(tlbFlush), 32'd1);
    // R11 base write with paging off: no flush
    cr3WrEn = 1; wrData = 32'h0001_2000; step();
    chk("R11 no flush PG off", 32'(tlbFlush), 32'd0);
    // R4 entry with PAE
    cr4WrEn = 1; wrData = 32'h0000_0020; step();
    chk("R9 PAE flush", 32'(tlbFlush), 32'd1);
    cr0WrEn = 1; wrData = 32'h8000_0001; step();
    chk("R4 lma set", 32'(lmaQ), 32'd1);
    chk("R2 et forced", cr0Q, 32'h8000_0011);
    cs64WrEn = 1; cs64In = 1; step();
    chk("R13 cs64 in long", 32'(cs64Flag), 32'd1);
    cr3WrEn = 1; wrData = 32'h0000_3000; step();
    chk("R11 flush PG on", 32'(tlbFlush), 32'd1);
    // R6 exit
    cr0WrEn = 1; wrData = 32'h0000_0001; step();
    chk("R6 lma cleared", 32'(lmaQ), 32'd0);
    chk("R6 cs64 cleared", 32'(cs64Flag), 32'd0);
    chk("R6 ipHiClear", 32'(ipHiClear), 32'd1);
    step();
    chk("R6 pulse one cycle", 32'(ipHiClear), 32'd0);
    // R12 same state: no effect
    a20SetEn = 1; a20In = 1; step();
    chk("R12 same state no exit", 32'(pipeExit), 32'd0);
    chk("R12 same state mask", a20Mask, 32'hFFFF_FFFF);
    a20SetEn = 1; a20In = 0; step();
    chk("R12 mask cleared bit", a20Mask, 32'hFFEF_FFFF);
    chk("R12 exit pulse", 32'(pipeExit), 32'd1);
    // R10 bit 9 in build without SSE
    cr4WrEn = 1; wrData = 32'h0000_0220; step();
    chk("R10 nosse bit9 dropped", cr4QN, 32'h0000_0020);
    chk("R10 sse bit9 kept", 32'(osfxsrFlag), 32'd1);
    chk("R9 no flush bit9 only", 32'(tlbFlush), 32'd0);
    // R7 addseg load in protected mode, then real mode forcing
    addsegWrEn = 1; addsegIn = 0; step();
    chk("R7 addseg loaded", 32'(addsegFlag), 32'd0);
    cr0WrEn = 1; wrData = 32'h0000_000E; step();
    chk("R7 addseg forced", 32'(addsegFlag), 32'd1);
    chk("R8 flags", {29'd0, tsFlag, emFlag, mpFlag}, 32'd7);
    addsegWrEn = 1; addsegIn = 0; step();
    chk("R7 load ignored real", 32'(addsegFlag), 32'd1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cr0WrEn = (r[2:0] == 0); cr3WrEn = (r[5:3] == 0); cr4WrEn = (r[8:6] == 0);
      lmeWrEn = (r[11:9] == 0); lmeIn = r[12];
      cs64WrEn = (r[14:13] == 0); cs64In = r[15];
      addsegWrEn = (r[17:16] == 0); addsegIn = r[18];
      a20SetEn = (r[20:19] == 0); a20In = r[21];
      wrData = $urandom;
      if (r[23:22] == 0) wrData = wrData | 32'h20;
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule